// File: doc/BRIEF.md
# Remote DMA Latch Port

This block moves a run of data between a host and local buffer memory through an external data latch. It moves one word per handshake. The host sets up a start address, a byte count, a direction and a width mode, then pulses `start`. The block works through the run on its own. The local memory cycle is abstracted as a request/done pair: `mem_req` is held until the memory answers with a one-cycle `mem_done`.

**Remote read.** The block raises the port request and reads one word from local memory. It then loads that word into the external latch with a one-cycle port-write strobe. After that it waits for the host's read acknowledge, which says the latch was emptied, before it fetches the next word.

**Remote write.** The block raises the port request and waits for the host's write acknowledge, which says the latch now holds new data. It then runs a local memory write. During that write it keeps the latch output enable asserted, so the latch contents drive the local bus.

After each completed transfer the address steps by 1 in byte mode or by 2 in word mode, and the byte count drops by the same step, stopping at zero. When the count runs out, the block drops the port request and gives a one-cycle `done` pulse.

Top module: `rdma_latch_port`

## Requirements
- R1: After reset, `port_req`, `mem_req`, `port_wr`, `port_rd_en`, `done` and `busy` are all 0.
- R2: In a remote read (`dir_write`=0), `mem_req`=1 with `mem_we`=0 and `port_req`=1 is held until `mem_done`. In the cycle after `mem_done`, `port_wr` is 1 for exactly one cycle, `latch_dout` equals the `mem_rdata` returned, and `mem_req` is 0.
- R3: After a read strobe that is not the last transfer, `mem_req` stays 0 until `host_rd_ack` is seen. A new read request is present in the cycle after the acknowledge.
- R4: In a remote write (`dir_write`=1), `port_req`=1 and `mem_req`=0 until `host_wr_ack` is seen. In the next cycle `mem_req`=1, `mem_we`=1 and `port_rd_en`=1, and `mem_wdata` equals `latch_din`. All three stay asserted until `mem_done`. `port_rd_en` is only ever 1 during such a write request.
- R5: The first transfer uses `start_addr`. Each later transfer's `mem_addr` is the previous one plus 1 (`word_mode`=0) or plus 2 (`word_mode`=1). The count falls by that step per transfer and saturates at 0, so an odd count in word mode ends after ceil(count/2) transfers.
- R6: In the cycle after the last transfer completes, `done`=1 for exactly one cycle, and `port_req`, `mem_req` and `busy` are 0.
- R7: A `start` with `byte_count`=0 makes no memory cycle and gives a `done` pulse in the next cycle.
- R8: Acknowledges while idle, an acknowledge of the wrong direction, and a `start` while busy are all ignored. None of them changes the outputs or the transfer sequence.
- R9: `mem_req`=1 implies `port_req`=1, and `port_wr` is never 1 together with `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a run (accepted only when idle) |
| dir_write | input | 1 | 1 = host to local memory, 0 = local memory to host |
| word_mode | input | 1 | 1 = 2-byte steps, 0 = 1-byte steps |
| start_addr | input | AW | First local address |
| byte_count | input | CW | Bytes in the run |
| host_rd_ack | input | 1 | Host has emptied the latch |
| host_wr_ack | input | 1 | Host has filled the latch |
| mem_done | input | 1 | Local memory cycle finished |
| mem_rdata | input | DW | Data from local memory (valid with mem_done) |
| latch_din | input | DW | External latch contents |
| port_req | output | 1 | Single-transfer port request |
| port_wr | output | 1 | Strobe that loads latch_dout into the latch |
| port_rd_en | output | 1 | Latch output enable onto the local bus |
| latch_dout | output | DW | Word presented to the latch |
| mem_req | output | 1 | Local memory cycle request |
| mem_we | output | 1 | Memory cycle is a write |
| mem_addr | output | AW | Local memory address |
| mem_wdata | output | DW | Write data toward local memory |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Each result has a fixed cycle in which it is due:
- A read request appears one cycle after `start` or `host_rd_ack`.
- The latch strobe appears one cycle after `mem_done`.
- A write request, with the latch enable, appears one cycle after `host_wr_ack`.
- `done` appears one cycle after the completing event.

The bench drives inputs and samples outputs on falling edges. Each check sits exactly one rising edge after the stimulus it depends on. Holds, such as no request while waiting for an acknowledge, are checked over several idle cycles before the acknowledge is given.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FETCH,
    PH_LOAD,
    PH_WAIT_RACK,
    PH_WAIT_WACK,
    PH_STORE
  } phase_t;
endpackage

// File: rtl/rdma_cursor.sv
module rdma_cursor #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          word_in,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] count_in,
  input  logic          advance,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] count,
  output logic          last
);
  logic word_q;

  function automatic logic [CW-1:0] step_of(input logic w);
    return w ? CW'(2) : CW'(1);
  endfunction

  function automatic logic [CW-1:0] shrink(input logic [CW-1:0] c, input logic w);
    return (c <= step_of(w)) ? '0 : c - step_of(w);
  endfunction

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] a, input logic w);
    return a + (w ? AW'(2) : AW'(1));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      count  <= '0;
      word_q <= 1'b0;
    end else if (load) begin
      addr   <= addr_in;
      count  <= count_in;
      word_q <= word_in;
    end else if (advance) begin
      addr  <= bump(addr, word_q);
      count <= shrink(count, word_q);
    end
  end

  assign last = (count <= step_of(word_q));

  // R5: the last advance empties the count
  p_last_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && last && !load) |=> (count == '0));
  // R5: the count never grows without a load
  p_count_monotone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (count <= $past(count)));
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   dir_write,
  input  logic   count_zero,
  input  logic   host_rd_ack,
  input  logic   host_wr_ack,
  input  logic   mem_done,
  input  logic   last,
  output logic   load,
  output logic   advance,
  output phase_t phase,
  output logic   done
);
  phase_t phase_nx;
  logic   done_nx;

  always_comb begin
    phase_nx = phase;
    load     = 1'b0;
    advance  = 1'b0;
    unique case (phase)
      PH_IDLE: if (start) begin
        load     = !count_zero;
        phase_nx = count_zero ? PH_IDLE : (dir_write ? PH_WAIT_WACK : PH_FETCH);
      end
      PH_FETCH:     if (mem_done) phase_nx = PH_LOAD;
      PH_LOAD: begin
        advance  = 1'b1;
        phase_nx = last ? PH_IDLE : PH_WAIT_RACK;
      end
      PH_WAIT_RACK: if (host_rd_ack) phase_nx = PH_FETCH;
      PH_WAIT_WACK: if (host_wr_ack) phase_nx = PH_STORE;
      PH_STORE: if (mem_done) begin
        advance  = 1'b1;
        phase_nx = last ? PH_IDLE : PH_WAIT_WACK;
      end
      default: phase_nx = PH_IDLE;
    endcase
  end

  assign done_nx = (phase == PH_IDLE && start && count_zero) || (advance && last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= phase_nx;
      done  <= done_nx;
    end
  end

  // R6: done lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: the latch strobe phase lasts one cycle
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD) |=> (phase != PH_LOAD));
  // R6: done is only seen while idle
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == PH_IDLE));
endmodule

// File: rtl/rdma_latch_port.sv
module rdma_latch_port
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_write,
  input  logic          word_mode,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] byte_count,
  input  logic          host_rd_ack,
  input  logic          host_wr_ack,
  input  logic          mem_done,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] latch_din,
  output logic          port_req,
  output logic          port_wr,
  output logic          port_rd_en,
  output logic [DW-1:0] latch_dout,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          done
);
  phase_t        phase;
  logic          load, advance, last;
  logic [CW-1:0] count;
  logic [DW-1:0] hold_q;
  logic          fetch_end;

  rdma_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write),
    .count_zero(byte_count == '0), .host_rd_ack(host_rd_ack),
    .host_wr_ack(host_wr_ack), .mem_done(mem_done), .last(last),
    .load(load), .advance(advance), .phase(phase), .done(done)
  );

  rdma_cursor #(.AW(AW), .CW(CW)) u_cursor (
    .clk(clk), .rst_n(rst_n), .load(load), .word_in(word_mode),
    .addr_in(start_addr), .count_in(byte_count), .advance(advance),
    .addr(mem_addr), .count(count), .last(last)
  );

  assign fetch_end = (phase == PH_FETCH) && mem_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= '0;
    else if (fetch_end) hold_q <= mem_rdata;
  end

  assign busy       = (phase != PH_IDLE);
  assign mem_req    = (phase == PH_FETCH) || (phase == PH_STORE);
  assign mem_we     = (phase == PH_STORE);
  assign port_wr    = (phase == PH_LOAD);
  assign port_rd_en = (phase == PH_STORE);
  assign port_req   = mem_req || port_wr || (phase == PH_WAIT_WACK);
  assign latch_dout = hold_q;
  assign mem_wdata  = latch_din;

  // R9: a memory cycle only runs under a port request
  p_req_cover_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> port_req);
  // R9: the latch strobe never overlaps a memory cycle
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_wr && mem_req));
  // R4: the latch drives the bus only during a memory write
  p_rd_en_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd_en |-> (mem_req && mem_we));
  // R3: no fetch while waiting for the read acknowledge
  p_wait_rack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_WAIT_RACK && !host_rd_ack) |=> !mem_req);
  // R8: acknowledges alone never wake an idle port
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);
  // R2: the strobe follows a finished fetch
  p_strobe_after_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_end |=> port_wr);
endmodule

// File: tb/tb_rdma_latch_port.sv
module tb_rdma_latch_port;
  localparam int AW = 16, CW = 16, DW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, dir_write = 0, word_mode = 0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic host_rd_ack = 0, host_wr_ack = 0, mem_done = 0;
  logic [DW-1:0] mem_rdata = '0, latch_din = '0;
  logic port_req, port_wr, port_rd_en, mem_req, mem_we, busy, done;
  logic [DW-1:0] latch_dout, mem_wdata;
  logic [AW-1:0] mem_addr;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  rdma_latch_port #(.AW(AW), .CW(CW), .DW(DW)) dut (.*);

  // {dir_write, word_mode, start_addr, byte_count}
  localparam logic [33:0] VEC [5] = '{
    {1'b0, 1'b0, 16'h0100, 16'd3},
    {1'b0, 1'b1, 16'h2000, 16'd4},
    {1'b1, 1'b0, 16'h0300, 16'd2},
    {1'b1, 1'b1, 16'h4000, 16'd5},
    {1'b0, 1'b1, 16'hFFF0, 16'd2}
  };

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic run(input logic dw, input logic wm, input logic [15:0] a0,
                     input logic [15:0] cnt, input logic inject);
    int n;
    logic [15:0] a;
    logic [15:0] d;
    n = wm ? (int'(cnt) + 1) / 2 : int'(cnt);
    a = a0;
    dir_write = dw; word_mode = wm; start_addr = a0; byte_count = cnt; start = 1;
    tick(); start = 0;
    chk(busy, "R2/R4 busy after start", busy, 1);
    for (int i = 0; i < n; i++) begin
      if (!dw) begin
        chk(mem_req && !mem_we && port_req, "R2 read request", {mem_req, mem_we, port_req}, 3'b101);
        chk(mem_addr == a, "R5 read address", mem_addr, a);
        tick(); tick();
        chk(mem_req, "R2 request held", mem_req, 1);
        d = a ^ 16'hA5C3;
        mem_rdata = d; mem_done = 1; tick(); mem_done = 0;
        chk(port_wr && !mem_req, "R2 strobe", {port_wr, mem_req}, 2'b10);
        chk(latch_dout == d, "R2 latch data", latch_dout, d);
        tick();
        chk(!port_wr, "R2 strobe one cycle", port_wr, 0);
        if (i != n - 1) begin
          if (inject) begin
            start = 1; start_addr = 16'hDEAD; byte_count = 16'd1; host_wr_ack = 1;
            tick(); start = 0; host_wr_ack = 0;
            tick();
            chk(!mem_req, "R8 wrong ack / busy start ignored", mem_req, 0);
          end else begin
            tick(); tick();
            chk(!mem_req, "R3 wait for read ack", mem_req, 0);
          end
          host_rd_ack = 1; tick(); host_rd_ack = 0;
        end
      end else begin
        chk(port_req && !mem_req, "R4 wait for write ack", {port_req, mem_req}, 2'b10);
        tick(); tick();
        chk(!mem_req, "R4 no write before ack", mem_req, 0);
        d = a * 16'd3 + 16'h11;
        latch_din = d; host_wr_ack = 1; tick(); host_wr_ack = 0;
        chk(mem_req && mem_we && port_rd_en, "R4 write cycle", {mem_req, mem_we, port_rd_en}, 3'b111);
        chk(mem_wdata == d, "R4 write data", mem_wdata, d);
        chk(mem_addr == a, "R5 write address", mem_addr, a);
        tick();
        chk(mem_req && port_rd_en, "R4 write held", {mem_req, port_rd_en}, 2'b11);
        mem_done = 1; tick(); mem_done = 0;
        if (i != n - 1)
          chk(port_req && !mem_req && !port_rd_en, "R4 next wait", {port_req, mem_req, port_rd_en}, 3'b100);
      end
      a = a + (wm ? 16'd2 : 16'd1);
    end
    chk(done && !port_req && !mem_req && !busy, "R6 done pulse", {done, port_req, mem_req, busy}, 4'b1000);
    tick();
    chk(!done, "R6 done one cycle", done, 0);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick();
    chk({port_req, mem_req, port_wr, port_rd_en, done, busy} == 6'b0, "R1 reset outputs",
        {port_req, mem_req, port_wr, port_rd_en, done, busy}, 0);
    rst_n = 1; tick();
    foreach (VEC[k]) run(VEC[k][33], VEC[k][32], VEC[k][31:16], VEC[k][15:0], 1'b0);
    // R8: start while busy and wrong-direction ack during a read wait
    run(1'b0, 1'b0, 16'h0500, 16'd2, 1'b1);
    // R7: zero count
    dir_write = 0; byte_count = 0; start_addr = 16'h0700; start = 1; tick(); start = 0;
    chk(done && !mem_req && !busy, "R7 zero count done", {done, mem_req, busy}, 3'b100);
    tick();
    chk(!done && !mem_req, "R7 no memory cycle", {done, mem_req}, 0);
    // R8: acknowledges while idle
    host_rd_ack = 1; host_wr_ack = 1; tick(); host_rd_ack = 0; host_wr_ack = 0;
    tick();
    chk(!mem_req && !port_req && !busy, "R8 idle acks ignored", {mem_req, port_req, busy}, 0);
    tick();
    chk(!mem_req && !done, "R8 idle stays quiet", {mem_req, done}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule